// File: doc/BRIEF.md
# Buffered SPI Master with Serial-Port Status Flags

This block is an SPI bus master that software drives the way it would drive a simple serial port. A byte written to the data register goes into a one-entry holding buffer. As soon as the shift engine is idle, the byte moves into the shift engine, so the next byte can be queued while the current one is on the wire. Every byte clocked in from the slave is copied into a receive register, and a read of the data port returns that register.

Three status flags report progress:
- **rx-ready** says that unread receive data is present.
- **tx-done** says that the wire has gone quiet with nothing queued.
- **buffer-free** says that a new byte may be written.

Each flag drives its own interrupt line through a separate enable. The serial clock is derived from the system clock by a programmable divider. Its idle level, its sampling edge and the bit order are all selectable.

Top module: `bspi_master`

## Requirements
- R1: After reset the status word reads 0x20 (only buffer-free set), `sck` equals `cpol`, read data is 0 and all interrupt lines are low.
- R2: A data write is accepted only while buffer-free (status bit 5) is 1 and `tx_en` is 1. Acceptance clears buffer-free on the next clock. A write made while the buffer is full, or while the transmitter is disabled, changes neither the buffer nor the wire.
- R3: When the buffer holds a byte, the shift engine is idle and `tx_en` is 1, the byte enters the shift engine on the next clock. Buffer-free reads 1 again from that clock on.
- R4: `sck` idles at `cpol`. During a frame it changes level every `clk_div`+1 system clocks, the first change coming `clk_div`+1 clocks after the frame starts, and one frame is 8 full `sck` periods.
- R5: With `cpha`=0 the first data bit is on `mosi` before the first `sck` edge, and `miso` is sampled on the first, third, … edges. With `cpha`=1 `mosi` is updated on those edges and `miso` is sampled on the second, fourth, … edges. With `lsb_first`=0 bit 7 goes first, otherwise bit 0 goes first, in both directions.
- R6: When a frame ends with `rx_en`=1, the received byte appears on `dat_rdata` and rx-ready (status bit 7) is set, one clock after the last `sck` edge. A new byte replaces an unread one without any indication.
- R7: A data read pulse clears rx-ready on the next clock, unless a frame completes in that same clock.
- R8: While `rx_en` is 0, rx-ready and the receive register are forced to 0.
- R9: tx-done (status bit 6) is set one clock after a frame ends, but only if no byte was waiting in the buffer at that moment.
- R10: tx-done clears on a `txc_ack` pulse or on a status write with bit 6 set. A set in the same clock takes priority.
- R11: Status bits 4 to 0 always read 0. A status write affects nothing except the tx-done clear through bit 6.
- R12: Each interrupt output is high exactly when its flag and its enable input are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmitter enable |
| rx_en | input | 1 | Receiver enable; low flushes receive state |
| cpol | input | 1 | Serial clock idle level |
| cpha | input | 1 | Sampling edge select |
| lsb_first | input | 1 | Bit order select |
| clk_div | input | DIV_W | Half-period length minus one, in system clocks |
| ie_rxc | input | 1 | rx-ready interrupt enable |
| ie_txc | input | 1 | tx-done interrupt enable |
| ie_dre | input | 1 | buffer-free interrupt enable |
| dat_wr | input | 1 | Data register write strobe |
| dat_wdata | input | DATA_W | Data register write value |
| dat_rd | input | 1 | Data register read strobe |
| dat_rdata | output | DATA_W | Receive register contents |
| sts_wr | input | 1 | Status register write strobe |
| sts_wdata | input | 8 | Status register write value |
| sts_rdata | output | 8 | Status word {rx-ready, tx-done, buffer-free, 5'b0} |
| txc_ack | input | 1 | tx-done interrupt acknowledge |
| irq_rxc | output | 1 | rx-ready interrupt |
| irq_txc | output | 1 | tx-done interrupt |
| irq_dre | output | 1 | buffer-free interrupt |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The properties assume that `cpol`, `cpha`, `lsb_first` and `clk_div` do not change while a frame is in flight, because the half-period and edge-role checks compare consecutive clocks under one configuration. They also assume that `miso` is settled at every rising system clock. The stimulus changes the configuration only after generous idle gaps that cover a full frame plus the flag update. It drives `miso` and all strobes on the falling system clock edge, with `miso` taken from a slave byte indexed by the number of bits the reference model has already sampled.

// File: rtl/bspi_pkg.sv
package bspi_pkg;

  typedef struct packed {
    logic cpol;
    logic cpha;
    logic lsb_first;
  } bspi_cfg_t;

  // Edges are numbered from zero within a frame; an odd index is a trailing edge.
  function automatic logic is_sample_edge(input logic cpha, input logic odd_edge);
    return odd_edge == cpha;
  endfunction

endpackage

// File: rtl/bspi_clkgen.sv
module bspi_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);

  logic [DIV_W-1:0] cnt;

  assign tick = run && (cnt == div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (!run || tick) cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end

  // R4
  half_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div != '0) |=> !tick);

  // R4
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt <= div));

endmodule

// File: rtl/bspi_shifter.sv
module bspi_shifter
  import bspi_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] load_data,
  input  bspi_cfg_t         cfg,
  input  logic              tick,
  input  logic              miso,
  output logic              busy,
  output logic              sck,
  output logic              mosi,
  output logic              done,
  output logic [DATA_W-1:0] rx_data
);

  localparam int EDGES = 2 * DATA_W;
  localparam int EW    = $clog2(EDGES);

  function automatic logic [DATA_W-1:0] flip(input logic [DATA_W-1:0] v);
    logic [DATA_W-1:0] r;
    for (int i = 0; i < DATA_W; i++) r[i] = v[DATA_W-1-i];
    return r;
  endfunction

  logic [EW-1:0]     edge_idx;
  logic              lvl;
  logic [DATA_W-1:0] tx_sr;
  logic [DATA_W-1:0] rx_sr;
  logic              mosi_q;
  logic              busy_q;
  logic              done_q;

  wire [DATA_W-1:0] ordered   = cfg.lsb_first ? flip(load_data) : load_data;
  wire              last_edge = tick && (edge_idx == EW'(EDGES - 1));
  wire              smp_now   = tick && is_sample_edge(cfg.cpha, edge_idx[0]);
  wire              drv_now   = tick && !is_sample_edge(cfg.cpha, edge_idx[0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edge_idx <= '0;
      lvl      <= 1'b0;
      tx_sr    <= '0;
      rx_sr    <= '0;
      mosi_q   <= 1'b0;
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= last_edge;
      if (start && !busy_q) begin
        busy_q   <= 1'b1;
        edge_idx <= '0;
        lvl      <= 1'b0;
        mosi_q   <= ordered[DATA_W-1];
        tx_sr    <= cfg.cpha ? ordered : (ordered << 1);
      end else if (tick) begin
        lvl      <= ~lvl;
        edge_idx <= edge_idx + 1'b1;
        if (smp_now) rx_sr <= {rx_sr[DATA_W-2:0], miso};
        if (drv_now) begin
          mosi_q <= tx_sr[DATA_W-1];
          tx_sr  <= tx_sr << 1;
        end
        if (last_edge) busy_q <= 1'b0;
      end
    end
  end

  assign busy    = busy_q;
  assign done    = done_q;
  assign mosi    = mosi_q;
  assign sck     = cfg.cpol ^ lvl;
  assign rx_data = cfg.lsb_first ? flip(rx_sr) : rx_sr;

  // R4
  sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> (sck == cfg.cpol));

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy_q);

  // R5
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !tick) |=> $stable(mosi_q));

endmodule

// File: rtl/bspi_regs.sv
module bspi_regs #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic              rx_en,
  input  logic              wr_data,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rd_data,
  input  logic              txc_clr_req,
  input  logic              busy,
  input  logic              done,
  input  logic [DATA_W-1:0] rx_data,
  output logic              start,
  output logic [DATA_W-1:0] tx_byte,
  output logic [DATA_W-1:0] rx_buf,
  output logic              rxc,
  output logic              txc,
  output logic              dre
);

  logic [DATA_W-1:0] tx_buf;
  logic              tx_full;

  wire wr_accept = wr_data && tx_en && !tx_full;
  wire txc_set   = done && !tx_full;

  assign start   = tx_en && tx_full && !busy;
  assign tx_byte = tx_buf;
  assign dre     = !tx_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_buf  <= '0;
      tx_full <= 1'b0;
    end else if (wr_accept) begin
      tx_buf  <= wdata;
      tx_full <= 1'b1;
    end else if (start) begin
      tx_full <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_buf <= '0;
      rxc    <= 1'b0;
    end else if (!rx_en) begin
      rx_buf <= '0;
      rxc    <= 1'b0;
    end else if (done) begin
      rx_buf <= rx_data;
      rxc    <= 1'b1;
    end else if (rd_data) begin
      rxc    <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           txc <= 1'b0;
    else if (txc_set)     txc <= 1'b1;
    else if (txc_clr_req) txc <= 1'b0;
  end

  // R1
  reset_dre_chk: assert property (@(posedge clk) !rst_n |=> dre);

  // R2
  wr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_accept |=> !dre);

  // R2
  wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && !dre) |=> $stable(tx_buf));

  // R3
  start_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (busy && dre));

  // R6
  rx_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && rx_en) |=> (rxc && rx_buf == $past(rx_data)));

  // R7
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data && rx_en && !done) |=> !rxc);

  // R8
  rx_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> (!rxc && rx_buf == '0));

  // R9
  txc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(txc) |-> !busy);

  // R10
  txc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (txc_clr_req && !txc_set) |=> !txc);

endmodule

// File: rtl/bspi_master.sv
module bspi_master
  import bspi_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic              rx_en,
  input  logic              cpol,
  input  logic              cpha,
  input  logic              lsb_first,
  input  logic [DIV_W-1:0]  clk_div,
  input  logic              ie_rxc,
  input  logic              ie_txc,
  input  logic              ie_dre,
  input  logic              dat_wr,
  input  logic [DATA_W-1:0] dat_wdata,
  input  logic              dat_rd,
  output logic [DATA_W-1:0] dat_rdata,
  input  logic              sts_wr,
  input  logic [7:0]        sts_wdata,
  output logic [7:0]        sts_rdata,
  input  logic              txc_ack,
  output logic              irq_rxc,
  output logic              irq_txc,
  output logic              irq_dre,
  output logic              sck,
  output logic              mosi,
  input  logic              miso
);

  localparam int RXC_BIT = 7;
  localparam int TXC_BIT = 6;
  localparam int DRE_BIT = 5;

  bspi_cfg_t         cfg;
  logic              tick, busy, done, start;
  logic              rxc, txc, dre;
  logic [DATA_W-1:0] rx_data, tx_byte, rx_buf;

  assign cfg = '{cpol: cpol, cpha: cpha, lsb_first: lsb_first};

  wire txc_clr_req = txc_ack || (sts_wr && sts_wdata[TXC_BIT]);

  bspi_clkgen #(.DIV_W(DIV_W)) u_clkgen (
    .clk (clk),
    .rst_n (rst_n),
    .run (busy),
    .div (clk_div),
    .tick (tick)
  );

  bspi_shifter #(.DATA_W(DATA_W)) u_shifter (
    .clk (clk),
    .rst_n (rst_n),
    .start (start),
    .load_data (tx_byte),
    .cfg (cfg),
    .tick (tick),
    .miso (miso),
    .busy (busy),
    .sck (sck),
    .mosi (mosi),
    .done (done),
    .rx_data (rx_data)
  );

  bspi_regs #(.DATA_W(DATA_W)) u_regs (
    .clk (clk),
    .rst_n (rst_n),
    .tx_en (tx_en),
    .rx_en (rx_en),
    .wr_data (dat_wr),
    .wdata (dat_wdata),
    .rd_data (dat_rd),
    .txc_clr_req (txc_clr_req),
    .busy (busy),
    .done (done),
    .rx_data (rx_data),
    .start (start),
    .tx_byte (tx_byte),
    .rx_buf (rx_buf),
    .rxc (rxc),
    .txc (txc),
    .dre (dre)
  );

  always_comb begin
    sts_rdata          = '0;
    sts_rdata[RXC_BIT] = rxc;
    sts_rdata[TXC_BIT] = txc;
    sts_rdata[DRE_BIT] = dre;
  end

  assign dat_rdata = rx_buf;
  assign irq_rxc   = rxc && ie_rxc;
  assign irq_txc   = txc && ie_txc;
  assign irq_dre   = dre && ie_dre;

endmodule

// File: tb/bspi_master_tb.sv
module bspi_master_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_en = 1'b0, rx_en = 1'b0;
  logic       cpol = 1'b0, cpha = 1'b0, lsb_first = 1'b0;
  logic [7:0] clk_div = 8'd0;
  logic       ie_rxc = 1'b0, ie_txc = 1'b0, ie_dre = 1'b0;
  logic       dat_wr = 1'b0, dat_rd = 1'b0, sts_wr = 1'b0, txc_ack = 1'b0;
  logic [7:0] dat_wdata = 8'd0, sts_wdata = 8'd0;
  logic       miso = 1'b0;
  logic [7:0] dat_rdata, sts_rdata;
  logic       irq_rxc, irq_txc, irq_dre, sck, mosi;

  int  n_checks = 0;
  int  n_fail = 0;
  int  cycles = 0;
  bit  finished = 0;
  logic [7:0] slv = 8'h00;

  always #4 clk = ~clk;

  bspi_master u_dut (
    .clk (clk), .rst_n (rst_n), .tx_en (tx_en), .rx_en (rx_en),
    .cpol (cpol), .cpha (cpha), .lsb_first (lsb_first), .clk_div (clk_div),
    .ie_rxc (ie_rxc), .ie_txc (ie_txc), .ie_dre (ie_dre),
    .dat_wr (dat_wr), .dat_wdata (dat_wdata), .dat_rd (dat_rd), .dat_rdata (dat_rdata),
    .sts_wr (sts_wr), .sts_wdata (sts_wdata), .sts_rdata (sts_rdata),
    .txc_ack (txc_ack), .irq_rxc (irq_rxc), .irq_txc (irq_txc), .irq_dre (irq_dre),
    .sck (sck), .mosi (mosi), .miso (miso)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] rev8(input logic [7:0] v);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = v[7-i];
    return r;
  endfunction

  function automatic logic pick_bit(input logic [7:0] b, input int k, input logic lsb);
    if (k > 7) return 1'b0;
    return lsb ? b[k] : b[7-k];
  endfunction

  // ---------------- behavioural reference model ----------------
  bit         m_busy = 0, m_lvl = 0, m_mosi = 0, m_done = 0, m_full = 0, m_rxc = 0, m_txc = 0;
  int         m_cnt = 0, m_e = 0, m_oidx = 0, m_ridx = 8;
  logic [7:0] m_buf = 0, m_frame = 0, m_rxacc = 0, m_rxbuf = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_lvl = 0; m_mosi = 0; m_done = 0; m_full = 0; m_rxc = 0; m_txc = 0;
      m_cnt = 0; m_e = 0; m_oidx = 0; m_ridx = 8;
      m_buf = 0; m_frame = 0; m_rxacc = 0; m_rxbuf = 0;
    end else begin
      bit tk, last, smp, strt, wok, tset, tclr;
      tk   = m_busy && (m_cnt == int'(clk_div));
      last = tk && (m_e == 15);
      smp  = tk && ((m_e % 2 == 1) == cpha);
      strt = tx_en && m_full && !m_busy;
      wok  = dat_wr && tx_en && !m_full;
      tset = m_done && !m_full;
      tclr = txc_ack || (sts_wr && sts_wdata[6]);
      if (!rx_en) begin m_rxbuf = 0; m_rxc = 0; end
      else if (m_done) begin m_rxbuf = m_rxacc; m_rxc = 1; end
      else if (dat_rd) m_rxc = 0;
      if (tset) m_txc = 1; else if (tclr) m_txc = 0;
      m_cnt = (!m_busy || tk) ? 0 : m_cnt + 1;
      m_done = last;
      if (strt) begin
        m_busy = 1; m_e = 0; m_lvl = 0; m_frame = m_buf;
        m_mosi = pick_bit(m_buf, 0, lsb_first);
        m_oidx = cpha ? 0 : 1; m_ridx = 0; m_rxacc = 0;
      end else if (tk) begin
        m_lvl = !m_lvl;
        m_e++;
        if (smp) begin
          m_rxacc[lsb_first ? m_ridx : 7 - m_ridx] = miso;
          m_ridx++;
        end else begin
          m_mosi = pick_bit(m_frame, m_oidx, lsb_first);
          m_oidx++;
        end
        if (last) m_busy = 0;
      end
      if (wok) begin m_buf = dat_wdata; m_full = 1; end
      else if (strt) m_full = 0;
    end
  end

  // Slave: sends its byte MSB first, one bit per sample taken.
  always @(negedge clk) miso <= (m_ridx < 8) ? slv[7 - m_ridx] : 1'b0;

  always @(posedge clk) begin
    #2;
    check("R4 sck", sck, cpol ^ m_lvl);
    check("R5 mosi", mosi, m_mosi);
    check("R6 rx-ready", sts_rdata[7], m_rxc);
    check("R9 tx-done", sts_rdata[6], m_txc);
    check("R2 buffer-free", sts_rdata[5], !m_full);
    check("R11 reserved", sts_rdata[4:0], 0);
    check("R6 rdata", dat_rdata, m_rxbuf);
    check("R12 irqs", {irq_rxc, irq_txc, irq_dre},
          {m_rxc && ie_rxc, m_txc && ie_txc, !m_full && ie_dre});
  end

  // ---------------- stimulus ----------------
  task automatic write_dat(input logic [7:0] b);
    dat_wr = 1; dat_wdata = b;
    @(negedge clk);
    dat_wr = 0;
  endtask

  task automatic pulse(ref logic s);
    s = 1; @(negedge clk); s = 0;
  endtask

  task automatic wait_frame(input int d);
    repeat (16 * (d + 1) + 6) @(negedge clk);
  endtask

  task automatic run_mode(input logic p, input logic h, input logic l, input logic [7:0] d,
                          input logic [7:0] tx, input logic [7:0] rx);
    int k;
    cpol = p; cpha = h; lsb_first = l; clk_div = d; slv = rx;
    repeat (2) @(negedge clk);
    check("R4 idle level", sck, p);
    write_dat(tx);
    k = 0;
    do begin @(negedge clk); k++; end while (sck == p && k < 100);
    check("R4 first edge delay", k, d + 2);
    k = 0;
    do begin @(negedge clk); k++; end while (sck != p && k < 100);
    check("R4 half period", k, d + 1);
    wait_frame(d);
    check("R5 received order", dat_rdata, l ? rev8(rx) : rx);
    check("R6 rx-ready", sts_rdata[7], 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 status", sts_rdata, 8'h20);
    check("R1 sck", sck, 0);
    check("R1 rdata", dat_rdata, 0);
    check("R1 irqs", {irq_rxc, irq_txc, irq_dre}, 0);

    // Writes with the transmitter off are dropped.
    write_dat(8'h99);
    check("R2 write with tx off", sts_rdata[5], 1);
    repeat (5) @(negedge clk);
    check("R4 no frame", sck, 0);

    tx_en = 1; rx_en = 1; clk_div = 8'd1; ie_dre = 1;
    @(negedge clk);
    check("R12 dre irq", irq_dre, 1);

    slv = 8'h3C;
    write_dat(8'hA5);
    check("R3 buffer held", sts_rdata[5], 0);
    check("R12 dre irq low", irq_dre, 0);
    @(negedge clk);
    check("R3 buffer drained", sts_rdata[5], 1);
    check("R5 first bit early", mosi, 1);
    wait_frame(1);
    check("R6 byte in", dat_rdata, 8'h3C);
    check("R6 rx-ready set", sts_rdata[7], 1);
    check("R9 tx-done set", sts_rdata[6], 1);
    check("R12 txc irq masked", irq_txc, 0);

    pulse(txc_ack);
    check("R10 ack clears", sts_rdata[6], 0);
    pulse(dat_rd);
    check("R7 read clears", sts_rdata[7], 0);

    // Back-to-back with a write made while the buffer is full.
    slv = 8'h81;
    write_dat(8'h5A);
    @(negedge clk);
    write_dat(8'hC3);
    write_dat(8'h77);
    check("R2 full write ignored", sts_rdata[5], 0);
    repeat (40) @(negedge clk);
    check("R9 no tx-done with queued byte", sts_rdata[6], 0);
    check("R3 queued byte moved", sts_rdata[5], 1);
    repeat (40) @(negedge clk);
    check("R9 tx-done after last", sts_rdata[6], 1);

    // Unread byte overwritten.
    slv = 8'h12;
    write_dat(8'h01);
    wait_frame(1);
    slv = 8'hED;
    write_dat(8'h02);
    wait_frame(1);
    check("R6 overwrite", dat_rdata, 8'hED);

    // Status write semantics.
    ie_txc = 1; ie_rxc = 1;
    @(negedge clk);
    check("R12 txc irq", irq_txc, 1);
    check("R12 rxc irq", irq_rxc, 1);
    sts_wr = 1; sts_wdata = 8'hBF;
    @(negedge clk);
    sts_wr = 0;
    check("R11 other bits no effect", sts_rdata, 8'hE0);
    sts_wr = 1; sts_wdata = 8'h40;
    @(negedge clk);
    sts_wr = 0;
    check("R10 write-one clears", sts_rdata[6], 0);

    // Receiver flush.
    rx_en = 0;
    @(negedge clk);
    check("R8 flush flag", sts_rdata[7], 0);
    check("R8 flush data", dat_rdata, 0);
    rx_en = 1;

    run_mode(0, 1, 0, 8'd0, 8'hB4, 8'h6D);
    run_mode(1, 0, 1, 8'd2, 8'h4E, 8'h1B);
    run_mode(1, 1, 1, 8'd3, 8'hF0, 8'hC5);
    run_mode(0, 0, 1, 8'd0, 8'h0F, 8'h92);

    repeat (4) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      finished = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

endmodule